// File: doc/BRIEF.md
# Double-Buffer Capture Interrupt Controller

This block sits between a capture engine and a CPU that trade two capture buffers back and forth. Whenever the engine completes a buffer it raises that buffer's full flag and moves on to the other buffer. The CPU hands a buffer back by pulsing a per-buffer supply strobe. If the engine must move on to a buffer that the CPU has not handed back, an overrun flag is raised.

All conditions share one level-sensitive interrupt request. Each condition has its own enable and its own acknowledge bit, so the CPU can clear the conditions one at a time. The overrun flag is sticky: it ignores the buffer acknowledges and clears only through its own acknowledge bit.

Every pin is a plain control or status signal. The block accepts an event in any cycle and never pushes back, so there is no valid/ready pair. The buffer count is a parameter with a default of 2.

Top module: `dbuf_irq_ctrl`

## Requirements
- R1: After reset, all status flags read 0, `active_buf` is 0 (buffer 1) and `irq` is low. No buffer is held in reserve.
- R2: A `fill_done` pulse sets the full flag of the buffer named by `active_buf` (status bit 0 for buffer 1, bit 1 for buffer 2). The flag is visible in the cycle after the pulse.
- R3: Each `fill_done` moves `active_buf` to the other buffer, alternating 0,1,0,1. Without `fill_done`, `active_buf` holds.
- R4: A `buf_supply[k]` pulse reserves buffer k. A `fill_done` whose next buffer is neither reserved nor supplied in the same cycle sets the overrun flag (status bit 2). Moving into a buffer uses up its reservation.
- R5: An acknowledge write (`ack_wr`=1) clears each flag whose `ack_data` bit is 1: bit 0 clears buffer 1, bit 1 clears buffer 2, bit 2 clears overrun. Bits at 0 have no effect, and nothing is cleared while `ack_wr` is 0.
- R6: Acknowledge bits 0 and 1 never clear the overrun flag.
- R7: If a flag's set event and its acknowledge arrive in the same cycle, the flag ends up set.
- R8: `irq` is high exactly while some flag is set and its `irq_en` bit is 1. It drops in the cycle after the acknowledge that clears the last enabled pending flag.
- R9: A condition whose `irq_en` bit is 0 still sets its status flag but does not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_done | input | 1 | Engine finished the active buffer (one-cycle pulse) |
| buf_supply | input | 2 | Per-buffer pulse: CPU has handed the buffer back |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_data | input | 3 | Acknowledge bits: [0] buffer 1, [1] buffer 2, [2] overrun |
| irq_en | input | 3 | Per-condition interrupt enable, same bit order as the flags |
| irq | output | 1 | Level-sensitive shared interrupt request |
| status | output | 3 | Flags: [0] buffer 1 full, [1] buffer 2 full, [2] overrun |
| active_buf | output | 1 | Index of the buffer the engine is filling |

## Verification
Flag updates and `active_buf` are due one clock edge after the event or acknowledge that causes them. `irq` follows the registered flags and the current `irq_en` with no extra delay. The bench holds a behavioural model that updates on the same edge from the sampled inputs. It compares `status`, `active_buf` and `irq` on every falling edge, and its directed checks sample one nanosecond after the edge that follows each stimulus.

// File: rtl/dbuf_irq_pkg.sv
package dbuf_irq_pkg;
  parameter int unsigned DEF_NBUF = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dbuf_cond_flag.sv
module dbuf_cond_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (ack_i)  flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);  // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !set_i) |=> !flag_o);  // R5
endmodule

// File: rtl/dbuf_buf_seq.sv
module dbuf_buf_seq #(
  parameter int unsigned NBUF = dbuf_irq_pkg::DEF_NBUF,
  localparam int unsigned AW  = dbuf_irq_pkg::idx_w(NBUF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_done,
  input  logic [NBUF-1:0] buf_supply,
  output logic [AW-1:0]   active,
  output logic [NBUF-1:0] full_set,
  output logic            ovr_set
);
  logic [NBUF-1:0] armed, armed_n;
  logic [AW-1:0]   nxt;

  assign nxt = (active == AW'(NBUF-1)) ? '0 : active + AW'(1);

  for (genvar i = 0; i < NBUF; i++) begin : g_set
    assign full_set[i] = fill_done && (active == AW'(i));
  end

  assign ovr_set = fill_done && !(armed[nxt] || buf_supply[nxt]);

  always_comb begin
    armed_n = armed | buf_supply;
    if (fill_done) armed_n[nxt] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= '0;
      active <= '0;
    end else begin
      armed <= armed_n;
      if (fill_done) active <= nxt;
    end
  end

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (active != $past(active)));  // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_done |=> $stable(active));  // R3
endmodule

// File: rtl/dbuf_irq_merge.sv
module dbuf_irq_merge #(
  parameter int unsigned NCOND = 3
) (
  input  logic [NCOND-1:0] flags,
  input  logic [NCOND-1:0] enables,
  output logic             req
);
  assign req = |(flags & enables);
endmodule

// File: rtl/dbuf_irq_ctrl.sv
module dbuf_irq_ctrl #(
  parameter int unsigned NBUF  = dbuf_irq_pkg::DEF_NBUF,
  localparam int unsigned NCOND = NBUF + 1,
  localparam int unsigned AW    = dbuf_irq_pkg::idx_w(NBUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_done,
  input  logic [NBUF-1:0]  buf_supply,
  input  logic             ack_wr,
  input  logic [NCOND-1:0] ack_data,
  input  logic [NCOND-1:0] irq_en,
  output logic             irq,
  output logic [NCOND-1:0] status,
  output logic [AW-1:0]    active_buf
);
  logic [NBUF-1:0]  full_set;
  logic             ovr_set;
  logic [NCOND-1:0] set_vec, ack_vec;

  dbuf_buf_seq #(.NBUF(NBUF)) u_seq (
    .clk(clk), .rst_n(rst_n), .fill_done(fill_done), .buf_supply(buf_supply),
    .active(active_buf), .full_set(full_set), .ovr_set(ovr_set)
  );

  assign set_vec = {ovr_set, full_set};
  assign ack_vec = ack_wr ? ack_data : '0;

  for (genvar c = 0; c < NCOND; c++) begin : g_flag
    dbuf_cond_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec[c]), .ack_i(ack_vec[c]),
      .flag_o(status[c])
    );
  end

  dbuf_irq_merge #(.NCOND(NCOND)) u_merge (
    .flags(status), .enables(irq_en), .req(irq)
  );

  AST_OVR_OWN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (status[NBUF] && !(ack_wr && ack_data[NBUF])) |=> status[NBUF]);  // R6
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr) |=> (irq || !$stable(irq_en)));  // R8
  AST_FULL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> status[$past(active_buf)]);  // R2
endmodule

// File: tb/dbuf_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dbuf_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fill_done = 1'b0;
  logic [1:0] buf_supply = '0;
  logic       ack_wr = 1'b0;
  logic [2:0] ack_data = '0;
  logic [2:0] irq_en = '0;
  logic       irq;
  logic [2:0] status;
  logic [0:0] active_buf;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_act = 0;
  int m_arm [2] = '{0, 0};
  int m_flag [3] = '{0, 0, 0};

  always #2.5 clk = ~clk;

  dbuf_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fill_done(fill_done), .buf_supply(buf_supply),
    .ack_wr(ack_wr), .ack_data(ack_data), .irq_en(irq_en), .irq(irq),
    .status(status), .active_buf(active_buf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_arm = '{0, 0}; m_flag = '{0, 0, 0};
    end else begin
      int nx;
      int set_f [3];
      nx = 1 - m_act;
      set_f = '{0, 0, 0};
      if (fill_done) begin
        set_f[m_act] = 1;
        if (m_arm[nx] == 0 && buf_supply[nx] == 1'b0) set_f[2] = 1;
      end
      for (int k = 0; k < 3; k++) begin
        if (set_f[k] == 1) m_flag[k] = 1;
        else if (ack_wr && ack_data[k]) m_flag[k] = 0;
      end
      for (int k = 0; k < 2; k++) if (buf_supply[k]) m_arm[k] = 1;
      if (fill_done) begin
        m_arm[nx] = 0;
        m_act = nx;
      end
    end
  end

  function automatic int model_status();
    return m_flag[0] + 2 * m_flag[1] + 4 * m_flag[2];
  endfunction

  function automatic int model_irq();
    return int'((m_flag[0] && irq_en[0]) || (m_flag[1] && irq_en[1]) ||
                (m_flag[2] && irq_en[2]));
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(status) == model_status(), "R2/R4/R5 status", int'(status), model_status());
      check(int'(active_buf) == m_act, "R3 active_buf", int'(active_buf), m_act);
      check(int'(irq) == model_irq(), "R8 irq", int'(irq), model_irq());
    end
  end

  task automatic cyc(input logic fd, input logic [1:0] sup, input logic aw, input logic [2:0] ad);
    fill_done = fd; buf_supply = sup; ack_wr = aw; ack_data = ad;
    @(posedge clk); #1;
    fill_done = 1'b0; buf_supply = '0; ack_wr = 1'b0; ack_data = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #20000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(status == 3'b000, "R1 status", int'(status), 0);
    check(active_buf == 1'b0, "R1 active_buf", int'(active_buf), 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // normal ping-pong, no overrun
    cyc(0, 2'b10, 0, 0);
    cyc(1, 2'b00, 0, 0);
    check(status == 3'b001, "R2 buf1 full", int'(status), 1);
    check(active_buf == 1'b1, "R3 toggled to buf2", int'(active_buf), 1);
    cyc(1, 2'b01, 0, 0);  // supply arrives same cycle
    check(status == 3'b011, "R2/R4 buf2 full, no overrun", int'(status), 3);
    check(active_buf == 1'b0, "R3 back to buf1", int'(active_buf), 0);

    // overrun: buffer 2 not supplied
    cyc(1, 2'b00, 0, 0);
    check(status[2] == 1'b1, "R4 overrun set", int'(status), 7);

    // ack without strobe and zero bits do nothing
    cyc(0, 2'b00, 0, 3'b111);
    check(status == 3'b111, "R5 no strobe no clear", int'(status), 7);
    cyc(0, 2'b00, 1, 3'b000);
    check(status == 3'b111, "R5 zero bits no clear", int'(status), 7);

    // enables and acks
    irq_en = 3'b111;
    #1 check(irq == 1'b1, "R8 irq high", int'(irq), 1);
    cyc(0, 2'b00, 1, 3'b001);
    check(status == 3'b110, "R5 ack1 only buf1", int'(status), 6);
    check(irq == 1'b1, "R8 still pending", int'(irq), 1);
    cyc(0, 2'b00, 1, 3'b011);
    check(status == 3'b100, "R6 overrun survives ack1/ack2", int'(status), 4);
    cyc(0, 2'b00, 1, 3'b100);
    check(status == 3'b000, "R5 ack overrun", int'(status), 0);
    check(irq == 1'b0, "R8 irq dropped", int'(irq), 0);

    // set and ack collide
    cyc(0, 2'b10, 0, 0);
    cyc(1, 2'b01, 1, 3'b010);  // active is buf2 here
    check(status[1] == 1'b1, "R7 set wins", int'(status), 2);
    cyc(0, 2'b00, 1, 3'b010);

    // disabled condition
    irq_en = 3'b011;
    cyc(1, 2'b00, 1, 3'b011);  // buffer 2 was supplied earlier: arm held
    cyc(1, 2'b00, 1, 3'b011);  // buffer 1 not supplied -> overrun
    check(status[2] == 1'b1, "R9 flag set while disabled", int'(status), 4);
    cyc(0, 2'b00, 1, 3'b011);
    check(irq == 1'b0, "R9 disabled does not drive irq", int'(irq), 0);
    irq_en = 3'b100;
    #1 check(irq == 1'b1, "R8 enable exposes pending", int'(irq), 1);
    cyc(0, 2'b00, 1, 3'b100);
    check(irq == 1'b0, "R8 drop after last ack", int'(irq), 0);

    repeat (4) @(posedge clk);
    #1 finish_run();
  end
endmodule